// File: doc/BRIEF.md
# Composite Sync Regenerator

This block produces a clean, active-low composite sync bit for a display from the separate horizontal and vertical sync lines of an older video source. It does not combine the two inputs with logic gates. It keeps a dot counter and a line counter that run on a local clock, and it shapes the output from those counters. Every pulse width and position is therefore fixed in clock ticks. Horizontal sync edges also keep arriving during the vertical sync interval, which many modern displays require in order to lock.

To stay locked to the source, each incoming sync line is resynchronised to the local clock. Its falling edge is then turned into a one-clock pulse. A horizontal edge reloads the dot counter with a small offset that covers the input latency. A vertical edge clears the line counter and leaves the dot counter alone, so a vertical edge that arrives part way into a line does not disturb horizontal timing. With no activity on the inputs the block free-runs from reset.

Top module: `csync_regen`

## Requirements
- R1: While reset is high the output is high (idle) and both counters are zero. On the first clock after reset the output shows dot 0 of line 0.
- R2: On a line that is not a vertical sync line, the output is low for dots 0 to HSYNC_TICKS-1 and high for the rest of the line. The output register adds one clock of delay relative to the counters.
- R3: On the last VSYNC_LINES lines of a frame, the output is low except during the final SERR_TICKS dots of each line, where it is high. This gives a falling edge at dot 0 of every line.
- R4: The dot counter counts 0 to LINE_TICKS-1 and wraps to 0. Each wrap advances the line counter, which counts 0 to FRAME_LINES-1 and wraps to 0.
- R5: Each sync input passes through two synchronizing flops and a falling-edge detector. Only a high-to-low transition acts, once. Holding an input low, or releasing it high, has no further effect. An input that falls between clock edges k and k+1 acts on the counters at edge k+3.
- R6: A detected horizontal edge loads the dot counter with RESYNC_DOT, overriding the count. The line counter still advances whenever the dot counter sat at LINE_TICKS-1.
- R7: A detected vertical edge clears the line counter to 0 and leaves the dot counter unchanged.
- R8: When both edges are detected in the same clock, both the dot reload and the line clear take effect.
- R9: With both inputs held high the block free-runs and repeats a frame every LINE_TICKS*FRAME_LINES clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local timing clock |
| rst | input | 1 | Synchronous active-high reset |
| hsync_in_n | input | 1 | Asynchronous active-low horizontal sync from the source |
| vsync_in_n | input | 1 | Asynchronous active-low vertical sync from the source |
| csync_n | output | 1 | Registered active-low composite sync |

## Verification
The hardest state to reach from the ports is a vertical edge that lands in the middle of a line, alone or in the same clock as a horizontal edge. Its only visible effect is that the vertical sync interval shifts many lines later. The bench drops the vertical input at a known dot position. It counts the exact number of clocks to where the regenerated interval must begin, and samples the last normal line before that point. A free-running design would already be in vertical sync there. A horizontal edge is forced at a dot where the free-running output would be high, so a late or missing reload shows up within two clocks.

// File: rtl/csr_pkg.sv
package csr_pkg;

    localparam int unsigned POS_W = 16;

    typedef struct packed {
        logic [POS_W-1:0] dot;
        logic [POS_W-1:0] line;
    } raster_pos_t;

    typedef enum logic {
        LINE_NORMAL = 1'b0,
        LINE_VBLANK = 1'b1
    } line_kind_t;

    function automatic line_kind_t classify_line(
        input logic [POS_W-1:0] line,
        input int unsigned      frame_lines,
        input int unsigned      vsync_lines
    );
        return (line >= POS_W'(frame_lines - vsync_lines)) ? LINE_VBLANK : LINE_NORMAL;
    endfunction

    function automatic logic sync_level(
        input line_kind_t       kind,
        input logic [POS_W-1:0] dot,
        input int unsigned      line_ticks,
        input int unsigned      hsync_ticks,
        input int unsigned      serr_ticks
    );
        if (kind == LINE_VBLANK)
            return (dot >= POS_W'(line_ticks - serr_ticks));
        return (dot >= POS_W'(hsync_ticks));
    endfunction

endpackage

// File: rtl/csr_edge_sync.sv
module csr_edge_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_n,
    output logic fall_pulse
);
    logic [STAGES-1:0] chain_q;
    logic              hist_q;

    always_ff @(posedge clk) begin
        if (rst) chain_q[0] <= 1'b1;
        else     chain_q[0] <= async_n;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain_q[s] <= 1'b1;
            else     chain_q[s] <= chain_q[s-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) hist_q <= 1'b1;
        else     hist_q <= chain_q[STAGES-1];
    end

    assign fall_pulse = hist_q & ~chain_q[STAGES-1];

    // R5: a detected edge lasts exactly one clock
    p_one_shot_r5: assert property (@(posedge clk) disable iff (rst)
        fall_pulse |=> !fall_pulse);

endmodule

// File: rtl/csr_raster_counter.sv
module csr_raster_counter
    import csr_pkg::*;
#(
    parameter int unsigned LINE_TICKS  = 766,
    parameter int unsigned FRAME_LINES = 313,
    parameter int unsigned RESYNC_DOT  = 65
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        h_edge,
    input  logic        v_edge,
    output raster_pos_t pos
);
    localparam logic [POS_W-1:0] DOT_LAST  = POS_W'(LINE_TICKS - 1);
    localparam logic [POS_W-1:0] LINE_LAST = POS_W'(FRAME_LINES - 1);
    localparam logic [POS_W-1:0] DOT_LOAD  = POS_W'(RESYNC_DOT);

    logic end_line, end_frame;
    assign end_line  = (pos.dot == DOT_LAST);
    assign end_frame = (pos.line == LINE_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            pos <= '0;
        end else begin
            if (h_edge)        pos.dot <= DOT_LOAD;
            else if (end_line) pos.dot <= '0;
            else               pos.dot <= pos.dot + 1'b1;

            if (v_edge)         pos.line <= '0;
            else if (end_line)  pos.line <= end_frame ? '0 : pos.line + 1'b1;
        end
    end

    initial begin
        assert (LINE_TICKS < (1 << POS_W) && FRAME_LINES < (1 << POS_W));
        assert (RESYNC_DOT < LINE_TICKS);
    end

    p_dot_range_r4: assert property (@(posedge clk) disable iff (rst)
        pos.dot <= DOT_LAST);
    p_line_range_r4: assert property (@(posedge clk) disable iff (rst)
        pos.line <= LINE_LAST);
    p_hreload_r6: assert property (@(posedge clk) disable iff (rst)
        h_edge |=> pos.dot == DOT_LOAD);
    p_vclear_r7: assert property (@(posedge clk) disable iff (rst)
        v_edge |=> pos.line == '0);
    p_vkeeps_dot_r7: assert property (@(posedge clk) disable iff (rst)
        (v_edge && !h_edge && !end_line) |=> pos.dot == $past(pos.dot) + 1'b1);

endmodule

// File: rtl/csr_sync_shaper.sv
module csr_sync_shaper
    import csr_pkg::*;
#(
    parameter int unsigned LINE_TICKS  = 766,
    parameter int unsigned FRAME_LINES = 313,
    parameter int unsigned VSYNC_LINES = 3,
    parameter int unsigned HSYNC_TICKS = 60,
    parameter int unsigned SERR_TICKS  = 56
) (
    input  logic        clk,
    input  logic        rst,
    input  raster_pos_t pos,
    output logic        csync_n
);
    line_kind_t kind;
    logic       level_d;

    always_comb begin
        kind    = classify_line(pos.line, FRAME_LINES, VSYNC_LINES);
        level_d = sync_level(kind, pos.dot, LINE_TICKS, HSYNC_TICKS, SERR_TICKS);
    end

    always_ff @(posedge clk) begin
        if (rst) csync_n <= 1'b1;
        else     csync_n <= level_d;
    end

    // R2: every line start produces a low output one clock later
    p_line_start_low_r2: assert property (@(posedge clk) disable iff (rst)
        (pos.dot == '0) |=> !csync_n);
    // R3: inside a vertical line, outside the high window, output is low
    p_vblank_low_r3: assert property (@(posedge clk) disable iff (rst)
        (kind == LINE_VBLANK && pos.dot < POS_W'(LINE_TICKS - SERR_TICKS)) |=> !csync_n);

endmodule

// File: rtl/csync_regen.sv
module csync_regen
    import csr_pkg::*;
#(
    parameter int unsigned LINE_TICKS  = 766,
    parameter int unsigned FRAME_LINES = 313,
    parameter int unsigned VSYNC_LINES = 3,
    parameter int unsigned HSYNC_TICKS = 60,
    parameter int unsigned SERR_TICKS  = 56,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned RESYNC_DOT  = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic hsync_in_n,
    input  logic vsync_in_n,
    output logic csync_n
);
    localparam int unsigned N_IN = 2;

    logic [N_IN-1:0] raw_n;
    logic [N_IN-1:0] edge_p;
    raster_pos_t     pos;

    assign raw_n = {vsync_in_n, hsync_in_n};

    for (genvar i = 0; i < N_IN; i++) begin : g_in
        csr_edge_sync #(.STAGES(SYNC_STAGES)) sync_i (
            .clk        (clk),
            .rst        (rst),
            .async_n    (raw_n[i]),
            .fall_pulse (edge_p[i])
        );
    end

    csr_raster_counter #(
        .LINE_TICKS  (LINE_TICKS),
        .FRAME_LINES (FRAME_LINES),
        .RESYNC_DOT  (RESYNC_DOT)
    ) cnt_i (
        .clk    (clk),
        .rst    (rst),
        .h_edge (edge_p[0]),
        .v_edge (edge_p[1]),
        .pos    (pos)
    );

    csr_sync_shaper #(
        .LINE_TICKS  (LINE_TICKS),
        .FRAME_LINES (FRAME_LINES),
        .VSYNC_LINES (VSYNC_LINES),
        .HSYNC_TICKS (HSYNC_TICKS),
        .SERR_TICKS  (SERR_TICKS)
    ) shp_i (
        .clk     (clk),
        .rst     (rst),
        .pos     (pos),
        .csync_n (csync_n)
    );

    // R8: simultaneous edges both land
    p_both_edges_r8: assert property (@(posedge clk) disable iff (rst)
        (edge_p[0] && edge_p[1]) |=> (pos.dot == POS_W'(RESYNC_DOT) && pos.line == '0));

endmodule

// File: tb/csync_regen_tb_top.sv
module csync_regen_tb_top;
    // small geometry: line 20 ticks, frame 6 lines (lines 4,5 vertical)
    localparam int LT = 20, FL = 6, VL = 2, HS = 4, SW = 3, RD = 3;
    localparam int NV = 16;
    localparam int VEC_N [NV] = '{1, 4, 5, 20, 21, 25, 80, 81, 85, 97, 98, 100, 101, 118, 121, 125};
    localparam bit VEC_E [NV] = '{0, 0, 1, 1,  0,  1,  1,  0,  0,  0,  1,  1,   0,   1,   0,   1};

    logic clk = 1'b0, rst = 1'b1, hs_n = 1'b1, vs_n = 1'b1;
    wire  cs_n;
    int   n_run = 0, n_fail = 0, cur = 0;

    always #2 clk = ~clk;

    csync_regen #(.LINE_TICKS(LT), .FRAME_LINES(FL), .VSYNC_LINES(VL),
                  .HSYNC_TICKS(HS), .SERR_TICKS(SW), .SYNC_STAGES(2),
                  .RESYNC_DOT(RD)) dut_i (
        .clk(clk), .rst(rst), .hsync_in_n(hs_n), .vsync_in_n(vs_n), .csync_n(cs_n));

    task automatic check(input string tag, input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s at edge %0d: got %b expected %b", tag, cur, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; hs_n = 1'b1; vs_n = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 idle high in reset", cs_n, 1'b1);
        rst = 1'b0;
        cur = 0;
    endtask

    task automatic step_to(input int n);
        while (cur < n) begin
            @(posedge clk);
            cur++;
        end
        @(negedge clk);
    endtask

    initial begin
        #(4 * 20000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        // free-run frame walk: R1 R2 R3 R4 R9
        do_reset();
        for (int i = 0; i < NV; i++) begin
            step_to(VEC_N[i]);
            check("R2/R3/R4/R9 free-run vector", cs_n, VEC_E[i]);
        end

        // R5 R6: horizontal edge at dot 7 reloads dot to RD at edge 10
        do_reset();
        step_to(7);  hs_n = 1'b0;
        step_to(11); check("R6 reload dot RD low", cs_n, 1'b0);
        step_to(12); check("R6 reload dot RD+1 high", cs_n, 1'b1);
        step_to(21); check("R6 old line start suppressed", cs_n, 1'b1);
        step_to(27); check("R6 line end shifted high", cs_n, 1'b1);
        step_to(28); check("R6 new line start low", cs_n, 1'b0);
        step_to(40); hs_n = 1'b1;   // R5: held low, then released
        step_to(48); check("R5 no retrigger line start", cs_n, 1'b0);
        step_to(52); check("R5 no retrigger pulse end", cs_n, 1'b1);

        // R7: vertical edge mid-line clears line, dot kept
        do_reset();
        step_to(30); vs_n = 1'b0;
        step_to(41); check("R7 dot unchanged line start", cs_n, 1'b0);
        step_to(85); check("R7 vertical interval postponed", cs_n, 1'b1);
        step_to(105); check("R7 vertical interval reached", cs_n, 1'b0);
        vs_n = 1'b1;

        // R8: both edges in one clock
        do_reset();
        step_to(30); vs_n = 1'b0; hs_n = 1'b0;
        step_to(34); check("R8 dot reload low", cs_n, 1'b0);
        step_to(35); check("R8 dot reload high", cs_n, 1'b1);
        step_to(95); check("R8 line cleared, still normal", cs_n, 1'b1);
        step_to(115); check("R8 vertical interval after clear", cs_n, 1'b0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule